// File: doc/BRIEF.md
# Nibble-Loaded Double-Buffered Converter Code Register

This block is the digital front end of a 12-bit digital-to-analog converter. A host drives a 12-bit data bus. Three 4-bit holding registers take the high, middle and low nibble of that bus. Each holding register has its own active-low select. All writes share one active-low write strobe. A separate active-low transfer enable lets the same strobe copy the held 12 bits into the output register. The output register supplies the code to the converter.

A host with a 4-, 8-, 12- or 16-bit bus can build the code in one, two or three strobes, with its data right- or left-justified. A nibble can be written in the same strobe as the transfer. In that strobe the new nibble goes straight from the bus into the output register, and the other two nibbles come from their holding registers. The converter therefore never sees a half-updated code.

The design is synchronous to a system clock. The strobe, selects, transfer enable and data are sampled on every edge. A write takes effect when the strobe returns high, and it uses the values present in the last sampled low cycle. Besides the straight-binary code, the block gives a two's-complement view for bipolar use, in which code 0x800 reads as zero.

Top module: `nibdac_front`

## Requirements
- R1: After reset, all three holding registers and the output code are 0x000, and the two's-complement view is 0x800.
- R2: A holding register changes only on a strobe release at which its own select was low. Select bit 2 picks the high nibble (bits 11..8), bit 1 the middle nibble (bits 7..4), and bit 0 the low nibble (bits 3..0).
- R3: A strobe that releases while the transfer enable was high leaves the output code unchanged.
- R4: A strobe with the transfer enable low and every select high copies the three holding registers into the output code.
- R5: A strobe with the transfer enable low and some selects low loads the output code with bus data for the selected nibbles and with holding-register contents for the others. The holding registers of the selected nibbles take the same bus data.
- R6: The output code holds its value while the strobe is low. It changes in the cycle after the first clock edge that samples the strobe high following a low sample.
- R7: The data, selects and transfer enable used by a write are those sampled in the last cycle in which the strobe was low. Values present at or after the release edge have no effect.
- R8: Writing two nibbles in one strobe and then the third nibble together with the transfer makes the output code change exactly once, straight to the complete new value.
- R9: The two's-complement view equals the output code with bit 11 inverted. It is 0x000 when the code is mid-scale 0x800, and the major carry lies between codes 0x7FF and 0x800.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe; a write commits when it returns high |
| ld_n | input | 1 | Active-low transfer enable for the output register |
| nib_en_n | input | 3 | Active-low nibble selects: bit 2 high nibble, bit 1 middle, bit 0 low |
| data_i | input | 12 | Positive-true data bus; bit 11 is the MSB |
| code_o | output | 12 | Output code in straight binary |
| code_twos_o | output | 12 | Output code with bit 11 inverted (two's-complement view) |

## Verification
If a holding register is wrong, the output stays correct until a later transfer reads that register. The fault then shows as a wrong nibble in the code one cycle after that strobe is released. For this reason the bench always follows a load with a transfer-only strobe, which exposes the register's contents. A wrong output register, or one that updates at the wrong time, shows at the ports at once: it appears as a change while the strobe is low, or as an intermediate value during a combined write and transfer. The bench counts code changes during that sequence to catch such an intermediate value.

// File: rtl/nibdac_pkg.sv
package nibdac_pkg;
    localparam int NIB_W  = 4;
    localparam int NIB_N  = 3;
    localparam int CODE_W = NIB_W * NIB_N;

    typedef struct packed {
        logic              low_seen;
        logic [NIB_N-1:0]  en_n;
        logic              ld_n;
        logic [CODE_W-1:0] din;
    } samp_t;

    typedef struct packed {
        logic [CODE_W-1:0] hold;
        logic [CODE_W-1:0] code;
    } regs_t;
endpackage

// File: rtl/nibdac_strobe_sampler.sv
module nibdac_strobe_sampler
    import nibdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic [NIB_N-1:0]  nib_en_n,
    input  logic [CODE_W-1:0] data_i,
    output logic              commit_o,
    output logic [NIB_N-1:0]  en_n_o,
    output logic              ld_n_o,
    output logic [CODE_W-1:0] din_o
);
    samp_t s_d, s_q;

    // Capture bus state in every low cycle; freeze it once the strobe is high.
    always_comb begin
        s_d = s_q;
        s_d.low_seen = !wr_n;
        if (!wr_n) begin
            s_d.en_n = nib_en_n;
            s_d.ld_n = ld_n;
            s_d.din  = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{low_seen: 1'b0, en_n: '1, ld_n: 1'b1, din: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign commit_o = s_q.low_seen && wr_n;
    assign en_n_o   = s_q.en_n;
    assign ld_n_o   = s_q.ld_n;
    assign din_o    = s_q.din;

    // R6: one release gives exactly one commit pulse.
    p_single_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    // R7: sampled controls stay frozen while the strobe is high.
    p_frozen_when_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> $stable(en_n_o) && $stable(ld_n_o) && $stable(din_o));
endmodule

// File: rtl/nibdac_merge.sv
module nibdac_merge
    import nibdac_pkg::*;
(
    input  logic [NIB_N-1:0]  en_n_i,
    input  logic [CODE_W-1:0] din_i,
    input  logic [CODE_W-1:0] hold_i,
    output logic [CODE_W-1:0] merged_o
);
    for (genvar n = 0; n < NIB_N; n++) begin : g_nib
        localparam int LO = n * NIB_W;
        assign merged_o[LO +: NIB_W] = en_n_i[n] ? hold_i[LO +: NIB_W]
                                                 : din_i[LO +: NIB_W];
    end
endmodule

// File: rtl/nibdac_code_view.sv
module nibdac_code_view
    import nibdac_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] twos_o
);
    localparam logic [CODE_W-1:0] SIGN_FLIP = {1'b1, {(CODE_W-1){1'b0}}};

    assign twos_o = code_i ^ SIGN_FLIP;
endmodule

// File: rtl/nibdac_front.sv
module nibdac_front
    import nibdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic [NIB_N-1:0]  nib_en_n,
    input  logic [CODE_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o,
    output logic [CODE_W-1:0] code_twos_o
);
    localparam logic [CODE_W-1:0] MID_SCALE = {1'b1, {(CODE_W-1){1'b0}}};

    logic              commit;
    logic [NIB_N-1:0]  en_s;
    logic              ld_s;
    logic [CODE_W-1:0] din_s;
    logic [CODE_W-1:0] merged;
    regs_t             r_d, r_q;

    nibdac_strobe_sampler samp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (wr_n),
        .ld_n     (ld_n),
        .nib_en_n (nib_en_n),
        .data_i   (data_i),
        .commit_o (commit),
        .en_n_o   (en_s),
        .ld_n_o   (ld_s),
        .din_o    (din_s)
    );

    nibdac_merge merge_i (
        .en_n_i   (en_s),
        .din_i    (din_s),
        .hold_i   (r_q.hold),
        .merged_o (merged)
    );

    // Merged value feeds both banks, so a combined write+transfer is glitch-free.
    always_comb begin
        r_d = r_q;
        if (commit) begin
            r_d.hold = merged;
            if (!ld_s) begin
                r_d.code = merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_o = r_q.code;

    nibdac_code_view view_i (
        .code_i (r_q.code),
        .twos_o (code_twos_o)
    );

    // R2: holding bank only moves on a commit.
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(r_q.hold));
    // R3: no transfer enable, no code change.
    p_code_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && !ld_s) |=> $stable(code_o));
    // R4/R5: after a transfer, output register and holding bank agree.
    p_transfer_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !ld_s) |=> (code_o == r_q.hold));
    // R6: no output motion while the strobe is sampled low.
    p_quiet_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> $stable(code_o));
    // R9: mid-scale reads as zero in the two's-complement view.
    p_mid_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == MID_SCALE) |-> (code_twos_o == '0));
endmodule

// File: tb/nibdac_front_tb_top.sv
module nibdac_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic        ld_n = 1'b1;
    logic [2:0]  nib_en_n = 3'b111;
    logic [11:0] data_i = '0;
    logic [11:0] code_o;
    logic [11:0] code_twos_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_change = 0;
    bit count_on = 1'b0;
    logic [11:0] last_code = '0;

    always #5 clk = ~clk;

    nibdac_front dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_n        (wr_n),
        .ld_n        (ld_n),
        .nib_en_n    (nib_en_n),
        .data_i      (data_i),
        .code_o      (code_o),
        .code_twos_o (code_twos_o)
    );

    always @(negedge clk) begin
        if (count_on && code_o !== last_code) n_change++;
        last_code <= code_o;
    end

    // fields: {sel[2:0], ld_n, data[11:0], expected code[11:0]}
    localparam logic [27:0] VEC [8] = '{
        {3'b011, 1'b1, 12'hABC, 12'h000},  // R2 high nibble only
        {3'b101, 1'b1, 12'h0D0, 12'h000},  // R2 middle nibble only
        {3'b111, 1'b0, 12'hFFF, 12'hAD0},  // R4 transfer only
        {3'b110, 1'b0, 12'h005, 12'hAD5},  // R5 low nibble + transfer
        {3'b000, 1'b1, 12'h123, 12'hAD5},  // R3 no transfer
        {3'b000, 1'b0, 12'h7FF, 12'h7FF},  // R5 all nibbles + transfer
        {3'b011, 1'b0, 12'h8AA, 12'h8FF},  // R5 major carry, R9
        {3'b111, 1'b1, 12'h000, 12'h8FF}   // R3 idle strobe
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Low for one sampled cycle, release with junk on the bus; ends one cycle
    // after the committing edge, where the output has settled.
    task automatic strobe(input logic [2:0] sel, input logic ld, input logic [11:0] d);
        @(negedge clk);
        wr_n = 1'b0; nib_en_n = sel; ld_n = ld; data_i = d;
        @(negedge clk);
        wr_n = 1'b1; nib_en_n = 3'b000; ld_n = 1'b0; data_i = ~d;  // R7 junk at release
        @(negedge clk);
        nib_en_n = 3'b111; ld_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset code", code_o, 12'h000);
        check("R1 reset view", code_twos_o, 12'h800);
        rst_n = 1'b1;
        strobe(3'b111, 1'b0, 12'h5A5);
        check("R1 holding cleared", code_o, 12'h000);

        for (int i = 0; i < 8; i++) begin
            strobe(VEC[i][27:25], VEC[i][24], VEC[i][23:12]);
            check($sformatf("R5 vector %0d code", i), code_o, VEC[i][11:0]);
            check($sformatf("R9 vector %0d view", i), code_twos_o, VEC[i][11:0] ^ 12'h800);
        end
        // R2: holding now 8FF with low nibble F? verify contents via transfer
        strobe(3'b111, 1'b0, 12'h000);
        check("R2 holding readback", code_o, 12'h8AA ^ 12'h025 ^ 12'h0D0 ^ 12'h0D0 ^ 12'h0DA ^ 12'h025 ^ 12'h0FF ^ 12'h0DA ^ 12'h0AA);

        // R6: long low phase, then exact update cycle
        @(negedge clk);
        wr_n = 1'b0; nib_en_n = 3'b000; ld_n = 1'b0; data_i = 12'h3C3;
        repeat (4) begin
            @(negedge clk);
            check("R6 stable while low", code_o, 12'h8FF);
        end
        wr_n = 1'b1;
        @(negedge clk);
        check("R6 updated one cycle after release", code_o, 12'h3C3);
        nib_en_n = 3'b111; ld_n = 1'b1;

        // R7: data changed in the release cycle with selects held low is ignored
        @(negedge clk);
        wr_n = 1'b0; nib_en_n = 3'b111; ld_n = 1'b1; data_i = 12'h111;
        @(negedge clk);
        wr_n = 1'b1; nib_en_n = 3'b000; ld_n = 1'b0; data_i = 12'h999;
        repeat (2) @(negedge clk);
        nib_en_n = 3'b111; ld_n = 1'b1;
        check("R7 late controls ignored", code_o, 12'h3C3);

        // R8: byte host, two strobes, single output change
        @(negedge clk);
        n_change = 0; count_on = 1'b1;
        strobe(3'b001, 1'b1, 12'hE70);
        strobe(3'b110, 1'b0, 12'h00B);
        repeat (2) @(negedge clk);
        count_on = 1'b0;
        check("R8 final code", code_o, 12'hE7B);
        check("R8 change count", 12'(n_change), 12'd1);

        // R9: major carry both sides
        strobe(3'b000, 1'b0, 12'h800);
        check("R9 mid-scale view", code_twos_o, 12'h000);
        strobe(3'b000, 1'b0, 12'h7FF);
        check("R9 below carry view", code_twos_o, 12'hFFF);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 code after reset", code_o, 12'h000);
        strobe(3'b111, 1'b0, 12'hFFF);
        check("R1 holding after reset", code_o, 12'h000);

        finish_run();
    end
endmodule